// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block drains bytes from a small transmit queue and sends each one as an asynchronous serial frame. Every frame opens with one low start bit. Data follows least significant bit first, then an optional parity bit, then one or two high stop bits. The line rests high between frames. The frame format is taken from static configuration inputs at the moment each frame begins. Bit timing comes from a single-cycle tick that the surrounding logic supplies at eight times the baud rate.

Software-facing logic writes bytes with a strobe and watches the free-slot count, which tells it how much more it may queue. Three controls act on the line directly: a flush drops everything that is queued, a break request holds the line low, and hardware flow control keeps a new frame from starting while the remote side is not ready.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `txd` is 1, `tx_active` is 0, `free_slots` equals the queue depth (16) and `tx_overflow` is 0.
- R2: A frame starts with a 0 start bit, followed by the data bits LSB first. When `cfg_eight_bits` is 1, 8 data bits are sent. When it is 0, only bits 6..0 are sent and bit 7 of the byte is ignored.
- R3: When `cfg_par_en` is 1, a parity bit follows the last data bit. `cfg_par_sel` chooses its value: 0 gives odd parity over the sent data bits, 1 gives even parity, 2 always gives 0 and 3 always gives 1. When `cfg_par_en` is 0, no parity bit is sent.
- R4: Each frame ends with one high stop bit, or with two when `cfg_two_stop` is 1.
- R5: Every bit lasts exactly 8 `tick8` pulses. `tx_active` rises together with the start bit, stays high through the last stop bit, and is 0 in the cycle after the last tick of that stop bit.
- R6: Bytes are sent in the order they were written. `free_slots` equals 16 minus the number of queued bytes and is updated one clock after a write or a removal.
- R7: A write while `free_slots` is 0 is dropped and sets `tx_overflow`. `tx_overflow` stays set until a flush or a reset.
- R8: `fifo_flush` discards all queued bytes. `free_slots` reads 16 and `tx_overflow` reads 0 on the next clock, and none of the discarded bytes is ever sent.
- R9: While `brk_cmd` is 1, `txd` is 0 from the next clock on, and no new frame starts.
- R10: While `cfg_flow_en` is 1 and `cts` is 0, no new frame starts. A queued byte is sent once `cts` becomes 1 or flow control is turned off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to queue |
| cfg_eight_bits | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_two_stop | input | 1 | 1: two stop bits |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_sel | input | 2 | Parity kind: 0 odd, 1 even, 2 zero, 3 one |
| cfg_flow_en | input | 1 | Gate frame starts on `cts` |
| cts | input | 1 | Remote ready (1 = may send) |
| tick8 | input | 1 | One-cycle pulse at 8x the baud rate |
| fifo_flush | input | 1 | Discard all queued bytes |
| brk_cmd | input | 1 | Hold the line low |
| txd | output | 1 | Serial output, registered |
| tx_active | output | 1 | High from the start bit through the last stop bit |
| free_slots | output | 5 | Free queue entries |
| tx_overflow | output | 1 | Sticky dropped-write flag |

## Verification
A byte written in one cycle changes `free_slots` at the next clock. The line then drops to the start bit no earlier than one clock after that, so the bench reads `free_slots` on the falling edge just after the write. It does not time the line from the write; it waits for `tx_active` to rise. From that point the bench counts the `tick8` pulses the design has consumed. Each bit is sampled on the falling edge before its fourth tick and again before its eighth, and `tx_active` must be low on the falling edge after the final stop-bit tick. Break, flush and overflow take effect one clock after the request, and the bench reads their effects on the falling edge that follows.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int DATA_W  = 8;
  localparam int FRAME_W = DATA_W + 4;  // start + data + parity + two stop

  typedef enum logic [1:0] {
    PAR_ODD  = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ZERO = 2'd2,
    PAR_ONE  = 2'd3
  } par_kind_t;

  // Whole frame, bit 0 first on the wire, unused tail filled with ones.
  function automatic logic [FRAME_W-1:0] frame_bits(
    input logic [DATA_W-1:0] d,
    input logic              eight,
    input logic              pen,
    input par_kind_t         kind
  );
    logic [FRAME_W-1:0] v;
    logic [DATA_W-1:0]  dm;
    logic               p;
    dm = eight ? d : {1'b0, d[DATA_W-2:0]};
    case (kind)
      PAR_ODD:  p = ~(^dm);
      PAR_EVEN: p = ^dm;
      PAR_ZERO: p = 1'b0;
      default:  p = 1'b1;
    endcase
    v    = '1;
    v[0] = 1'b0;
    if (eight) v[DATA_W:1]   = d;
    else       v[DATA_W-1:1] = d[DATA_W-2:0];
    if (pen) begin
      if (eight) v[DATA_W+1] = p;
      else       v[DATA_W]   = p;
    end
    return v;
  endfunction

  function automatic logic [3:0] frame_len(
    input logic eight,
    input logic pen,
    input logic two
  );
    return 4'd9 + {3'd0, eight} + {3'd0, pen} + {3'd0, two};
  endfunction

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   free,
  output logic                         ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          full, do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem[rd_ptr];
  assign free    = CW'(DEPTH) - cnt;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) ovf <= 1'b0;
    else if (push && full) ovf <= 1'b1;
  end

  // R6: occupancy never exceeds the depth
  a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  // R7: a write into a full queue leaves it full and raises the flag
  a_r7_full_drop: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> (full && ovf));

  // R8: flush empties the queue and clears the flag
  a_r8_flush_empty: assert property (@(posedge clk) disable iff (rst)
    flush |=> (empty && !ovf));

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int OVS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              brk,
  input  logic              flow_en,
  input  logic              cts,
  input  logic              cfg_eight,
  input  logic              cfg_two,
  input  logic              cfg_pen,
  input  logic [1:0]        cfg_psel,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              pop,
  output logic              line,
  output logic              busy
);
  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;

  logic [CW-1:0]      cnt_q;
  logic [3:0]         left_q;
  logic [FRAME_W-1:0] shf_q;
  logic               busy_q, line_q;
  logic               start, bit_end, next_bit;

  assign start   = !busy_q && !fifo_empty && !brk && (!flow_en || cts);
  assign bit_end = busy_q && tick && (cnt_q == CW'(OVS-1));
  assign pop     = start;
  assign line    = line_q;
  assign busy    = busy_q;

  always_comb begin
    if (start)        next_bit = 1'b0;
    else if (bit_end) next_bit = (left_q == 4'd0) ? 1'b1 : shf_q[1];
    else if (busy_q)  next_bit = shf_q[0];
    else              next_bit = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      left_q <= '0;
      shf_q  <= '1;
      line_q <= 1'b1;
    end else begin
      line_q <= brk ? 1'b0 : next_bit;
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        shf_q  <= frame_bits(fifo_data, cfg_eight, cfg_pen, par_kind_t'(cfg_psel));
        left_q <= frame_len(cfg_eight, cfg_pen, cfg_two) - 4'd1;
      end else if (busy_q && tick) begin
        if (bit_end) begin
          cnt_q <= '0;
          if (left_q == 4'd0) begin
            busy_q <= 1'b0;
          end else begin
            left_q <= left_q - 4'd1;
            shf_q  <= {1'b1, shf_q[FRAME_W-1:1]};
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R9: break drives the line low on the next clock
  a_r9_break_low: assert property (@(posedge clk) disable iff (rst)
    brk |=> !line_q);

  // R9: no frame begins during break
  a_r9_no_start: assert property (@(posedge clk) disable iff (rst)
    (brk && !busy_q) |=> !busy_q);

  // R10: flow control holds back a new frame
  a_r10_cts_block: assert property (@(posedge clk) disable iff (rst)
    (flow_en && !cts && !busy_q) |=> !busy_q);

  // R1: a low line without break only happens inside a frame
  a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
    !brk |=> (line_q || busy_q));

  // R2: a started frame shows its start bit on the next clock
  a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
    start |=> (busy_q && !line_q));

  // R5: bit position advances only on a tick
  a_r5_tick_hold: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !tick) |=> ($stable(cnt_q) && $stable(left_q) && $stable(shf_q)));

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int FIFO_DEPTH = 16,
  parameter int OVS        = 8,
  localparam int FREE_W    = $clog2(FIFO_DEPTH+1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              cfg_eight_bits,
  input  logic              cfg_two_stop,
  input  logic              cfg_par_en,
  input  logic [1:0]        cfg_par_sel,
  input  logic              cfg_flow_en,
  input  logic              cts,
  input  logic              tick8,
  input  logic              fifo_flush,
  input  logic              brk_cmd,
  output logic              txd,
  output logic              tx_active,
  output logic [FREE_W-1:0] free_slots,
  output logic              tx_overflow
);
  logic       q_empty, q_pop;
  logic [7:0] q_data;

  uart_tx_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .flush (fifo_flush),
    .push  (wr_en),
    .din   (wr_data),
    .pop   (q_pop),
    .dout  (q_data),
    .empty (q_empty),
    .free  (free_slots),
    .ovf   (tx_overflow)
  );

  uart_tx_framer #(.OVS(OVS)) u_framer (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick8),
    .brk        (brk_cmd),
    .flow_en    (cfg_flow_en),
    .cts        (cts),
    .cfg_eight  (cfg_eight_bits),
    .cfg_two    (cfg_two_stop),
    .cfg_pen    (cfg_par_en),
    .cfg_psel   (cfg_par_sel),
    .fifo_empty (q_empty),
    .fifo_data  (q_data),
    .pop        (q_pop),
    .line       (txd),
    .busy       (tx_active)
  );

endmodule

// File: tb/test_uart_frame_tx.sv
module test_uart_frame_tx;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 4;

  logic       clk = 1'b0, rst = 1'b1;
  logic       wr_en = 0, cfg_eight_bits = 1, cfg_two_stop = 0, cfg_par_en = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] cfg_par_sel = 0;
  logic       cfg_flow_en = 0, cts = 1, tick8 = 0, fifo_flush = 0, brk_cmd = 0;
  logic       txd, tx_active, tx_overflow;
  logic [4:0] free_slots;

  int total = 0, bad = 0;
  logic [7:0] exp_q[$];

  uart_frame_tx i_uart_frame_tx (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_eight_bits(cfg_eight_bits), .cfg_two_stop(cfg_two_stop),
    .cfg_par_en(cfg_par_en), .cfg_par_sel(cfg_par_sel),
    .cfg_flow_en(cfg_flow_en), .cts(cts), .tick8(tick8),
    .fifo_flush(fifo_flush), .brk_cmd(brk_cmd), .txd(txd),
    .tx_active(tx_active), .free_slots(free_slots), .tx_overflow(tx_overflow)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    int tdiv = 0;
    forever begin
      @(posedge clk); #1;
      tdiv  = (tdiv + 1) % TDIV;
      tick8 = (tdiv == 0);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void mk_frame(input logic [7:0] d, input logic e, input logic pen,
                                   input logic [1:0] ps, input logic two,
                                   output logic [11:0] v, output int len);
    int nd, ones;
    logic p;
    nd = e ? 8 : 7;
    ones = 0;
    v = '1;
    v[0] = 1'b0;
    for (int i = 0; i < nd; i++) begin
      v[1+i] = d[i];
      ones += int'(d[i]);
    end
    case (ps)
      2'd0: p = (ones % 2 == 0);
      2'd1: p = (ones % 2 == 1);
      2'd2: p = 1'b0;
      default: p = 1'b1;
    endcase
    if (pen) v[1+nd] = p;
    len = 1 + nd + int'(pen) + 1 + int'(two);
  endfunction

  // Line monitor: counts consumed ticks from the rise of tx_active.
  bit         mon_on = 0, mon_end = 0;
  int         mk = 0, mlen = 0;
  logic [11:0] mvec;
  always @(negedge clk) begin
    if (!rst) begin
      if (mon_end) begin
        chk(!tx_active && txd, "R5 active low after last stop", int'(tx_active), 0);
        mon_end = 0;
      end else begin
        if (!mon_on && tx_active) begin
          if (exp_q.size() == 0) begin
            chk(0, "R8 frame with nothing queued", 1, 0);
            mlen = 10; mvec = '1; mvec[0] = 0;
          end else begin
            mk_frame(exp_q.pop_front(), cfg_eight_bits, cfg_par_en, cfg_par_sel,
                     cfg_two_stop, mvec, mlen);
          end
          mon_on = 1;
          mk = 0;
        end
        if (mon_on) begin
          if (!tx_active) begin
            chk(0, "R5 active dropped early", mk, mlen*8);
            mon_on = 0;
          end else if (tick8) begin
            if ((mk % 8) == 3 || (mk % 8) == 7)
              chk(txd == mvec[mk/8], "R2 R3 R4 line bit", int'(txd), int'(mvec[mk/8]));
            mk++;
            if (mk == mlen*8) begin
              mon_on = 0;
              mon_end = 1;
            end
          end
        end
      end
    end
  end

  task automatic write_byte(input logic [7:0] b, input bit expect_sent);
    @(posedge clk); #1;
    wr_en = 1; wr_data = b;
    @(posedge clk); #1;
    wr_en = 0;
    if (expect_sent) exp_q.push_back(b);
  endtask

  task automatic drain();
    do @(negedge clk);
    while (exp_q.size() != 0 || mon_on || mon_end || tx_active);
    @(negedge clk);
  endtask

  task automatic run_tests();
    logic [7:0] corner [2];
    corner[0] = 8'h80;
    corner[1] = 8'hFF;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1
    chk(txd == 1, "R1 reset line", int'(txd), 1);
    chk(tx_active == 0, "R1 reset active", int'(tx_active), 0);
    chk(free_slots == 16, "R1 reset free", int'(free_slots), 16);
    chk(tx_overflow == 0, "R1 reset overflow", int'(tx_overflow), 0);

    // R2 R3: directed corners, every parity kind and both data widths
    for (int ps = 0; ps < 4; ps++)
      for (int e = 0; e < 2; e++)
        for (int c = 0; c < 2; c++) begin
          cfg_par_en = 1; cfg_par_sel = 2'(ps); cfg_eight_bits = e[0];
          cfg_two_stop = c[0];
          write_byte(corner[c], 1);
          drain();
        end

    // R6: random formats and bursts, order must hold
    for (int t = 0; t < 24; t++) begin
      cfg_eight_bits = 1'($urandom);
      cfg_two_stop   = 1'($urandom);
      cfg_par_en     = 1'($urandom);
      cfg_par_sel    = 2'($urandom);
      for (int n = 0; n < 1 + int'($urandom % 4); n++)
        write_byte(8'($urandom), 1);
      drain();
    end

    // R7 R6: fill while flow control blocks, then overflow
    cfg_eight_bits = 1; cfg_par_en = 0; cfg_two_stop = 0;
    cfg_flow_en = 1; cts = 0;
    for (int i = 0; i < 16; i++) begin
      write_byte(8'(i), 1);
      @(negedge clk);
      chk(free_slots == 5'(15 - i), "R6 free count", int'(free_slots), 15 - i);
    end
    write_byte(8'h5A, 0);
    @(negedge clk);
    chk(free_slots == 0, "R7 free stays zero", int'(free_slots), 0);
    chk(tx_overflow == 1, "R7 overflow set", int'(tx_overflow), 1);
    repeat (20) @(negedge clk);
    chk(tx_overflow == 1, "R7 overflow sticky", int'(tx_overflow), 1);
    chk(tx_active == 0, "R10 held by cts", int'(tx_active), 0);

    // R8: flush discards, nothing is sent afterwards
    @(posedge clk); #1 fifo_flush = 1;
    @(posedge clk); #1 fifo_flush = 0;
    exp_q.delete();
    @(negedge clk);
    chk(free_slots == 16, "R8 free after flush", int'(free_slots), 16);
    chk(tx_overflow == 0, "R8 overflow cleared", int'(tx_overflow), 0);
    cts = 1;
    repeat (300) @(negedge clk);
    chk(tx_active == 0 && txd == 1, "R8 no frame after flush", int'(tx_active), 0);

    // R10: held byte goes out when cts returns
    cts = 0;
    write_byte(8'hC3, 1);
    repeat (150) @(negedge clk);
    chk(tx_active == 0, "R10 no start while cts low", int'(tx_active), 0);
    chk(free_slots == 15, "R10 byte still queued", int'(free_slots), 15);
    cts = 1;
    drain();
    chk(free_slots == 16, "R10 sent after cts", int'(free_slots), 16);
    cfg_flow_en = 0; cts = 0;
    write_byte(8'h3C, 1);
    drain();
    chk(free_slots == 16, "R10 flow off ignores cts", int'(free_slots), 16);
    cts = 1;

    // R9: break holds the line low and blocks new frames
    @(posedge clk); #1 brk_cmd = 1;
    @(posedge clk);
    write_byte(8'h96, 1);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i % 8 == 0) begin
        chk(txd == 0, "R9 line low in break", int'(txd), 0);
        chk(tx_active == 0, "R9 no start in break", int'(tx_active), 0);
      end
    end
    chk(free_slots == 15, "R9 byte waits", int'(free_slots), 15);
    @(posedge clk); #1 brk_cmd = 0;
    drain();
    chk(txd == 1, "R9 line idle after break", int'(txd), 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule